// File: doc/BRIEF.md
# Circular-Buffer Sample Capture Engine

This block records a parallel data bus into a ring memory so that the samples around an event of interest can be examined later. Once armed, it keeps writing samples and overwrites the oldest slot when the ring is full. A trigger input fixes where recording ends. After the trigger sample, a programmable number of further samples is stored, and then the engine freezes the memory.

An optional storage qualifier compares each sample against a mask and a value. Samples that do not match are neither stored nor counted. The sample rate comes from one of two sources. It can follow the producer's own valid strobe, or an internal divider can open the input once every `rate_div+1` clock cycles. After the record is frozen, the read port returns samples relative to the oldest retained entry. The engine also reports the ring address of the trigger sample, whether the ring has wrapped, and how many samples are valid.

The sample input is a valid/ready stream. In external mode `samp_ready` is held high, so the engine never back-pressures the producer. In internal-rate mode `samp_ready` is high for exactly one cycle per rate period. A sample is taken only in a cycle where `samp_valid` and `samp_ready` are both high. The producer must hold `samp_data` and `trig` steady while `samp_valid` waits for `samp_ready`. Samples taken while the engine is idle or done are consumed and discarded.

Top module: `cap_engine`

## Requirements
- R1: After reset, `state` is 0 (idle), and `wrapped`, `trig_idx`, `rec_len` and `rd_valid` are all 0. The state encoding is: 0 idle, 1 armed, 2 post-trigger, 3 done.
- R2: With `use_int_clk`=0, `samp_ready` is always 1. With `use_int_clk`=1, `samp_ready` is high one cycle in every `rate_div+1`. A sample is taken only when `samp_valid` and `samp_ready` are both high.
- R3: In states 1 and 2, each taken sample that is qualified is written at the current write pointer. The pointer then increments modulo DEPTH, so new samples overwrite the oldest ones.
- R4: `wrapped` rises when ring address DEPTH-1 is written and stays high until re-arm. `rec_len` equals DEPTH when `wrapped` is 1, and otherwise equals the number of stored samples.
- R5: With `qual_en`=1, a sample is stored only if `(samp_data & qual_mask) == (qual_value & qual_mask)`. A sample that does not match is not stored, does not move the pointer, and cannot act as the trigger.
- R6: In state 1, a stored sample that has `trig`=1 becomes the trigger sample, and its ring address is latched into `trig_idx`. The state then moves to 2, or to 3 if `post_cnt` is 0. A `trig` that arrives without a stored sample has no effect.
- R7: After the trigger sample, exactly `post_cnt` more samples are stored, and then the state becomes 3. Nothing is written in state 3.
- R8: `trig` asserted in state 0 or state 3 is ignored: the state and the stored record stay unchanged.
- R9: In state 3, `rd_en` with `rd_idx` produces `rd_valid`=1 one cycle later, with `rd_data` taken from ring address (oldest + `rd_idx`) mod DEPTH. Here oldest is the write pointer if `wrapped` is 1, and 0 otherwise. `rd_en` in any other state leaves `rd_valid` at 0.
- R10: A pulse on `arm`, from any state, moves the engine to state 1 and clears the write pointer, `wrapped` and `trig_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse that starts a new acquisition |
| trig | input | 1 | Trigger flag that travels with the sample |
| use_int_clk | input | 1 | 1 selects the internal rate divider |
| rate_div | input | RW | Internal rate period minus one |
| post_cnt | input | PW | Number of samples stored after the trigger |
| qual_en | input | 1 | Enables the storage qualifier |
| qual_mask | input | DW | Qualifier compare mask |
| qual_value | input | DW | Qualifier compare value |
| samp_valid | input | 1 | Sample stream valid |
| samp_ready | output | 1 | Sample stream ready |
| samp_data | input | DW | Sample bus |
| rd_en | input | 1 | Read request |
| rd_idx | input | AW | Read index relative to the oldest sample |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| state | output | 2 | Engine state |
| wrapped | output | 1 | Ring has filled at least once |
| trig_idx | output | AW | Ring address of the trigger sample |
| rec_len | output | AW+1 | Number of valid samples |

## Verification
Several record shapes are tested:
- A short record that never wraps checks oldest = 0 addressing and the transition through the post-trigger state.
- A record that runs well past the ring size checks that reads begin at the write pointer, and that the trigger samples land on the newest addresses.
- A post-trigger count of zero separates the direct armed-to-done path from the counting path.

A qualified run mixes matching and non-matching bytes, with triggers on both kinds. This shows that skipped samples neither advance the pointer nor trigger. A run at the internal rate checks the ready spacing, and triggers sent in idle and done check that they are ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_rate_gen.sv
module cap_rate_gen #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_int,
  input  logic [RW-1:0] rate_div,
  output logic          open_o
);
  logic [RW-1:0] cnt_q;
  logic          tick;

  assign tick   = (cnt_q == '0);
  assign open_o = !use_int || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick)   cnt_q <= rate_div;
    else             cnt_q <= cnt_q - 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (use_int && open_o && rate_div != '0) |=> !open_o); // R2
endmodule

// File: rtl/cap_qual.sv
module cap_qual #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] value,
  input  logic          enable,
  output logic          pass_o
);
  logic [DW-1:0] diff;
  assign diff   = (data ^ value) & mask;
  assign pass_o = !enable || (diff == '0);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int AW = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          take,
  input  logic          pass,
  input  logic          trig,
  input  logic [PW-1:0] post_cnt,
  output logic          we_o,
  output logic [AW-1:0] wptr_o,
  output cap_state_e    state_o,
  output logic          wrapped_o,
  output logic [AW-1:0] trig_idx_o,
  output logic [AW:0]   rec_len_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    st_q;
  logic [AW-1:0] ptr_q;
  logic          wrap_q;
  logic [AW-1:0] tidx_q;
  logic [PW-1:0] left_q;
  logic          acq;
  logic          store;

  assign acq   = (st_q == CAP_ARMED) || (st_q == CAP_POST);
  assign store = take && pass && acq && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      ptr_q  <= '0;
      wrap_q <= 1'b0;
      tidx_q <= '0;
      left_q <= '0;
    end else if (arm) begin
      st_q   <= CAP_ARMED;
      ptr_q  <= '0;
      wrap_q <= 1'b0;
      tidx_q <= '0;
      left_q <= '0;
    end else if (store) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) wrap_q <= 1'b1;
      if (st_q == CAP_ARMED) begin
        if (trig) begin
          tidx_q <= ptr_q;
          left_q <= post_cnt;
          st_q   <= (post_cnt == '0) ? CAP_DONE : CAP_POST;
        end
      end else begin
        left_q <= left_q - 1'b1;
        if (left_q == PW'(1)) st_q <= CAP_DONE;
      end
    end
  end

  assign we_o       = store;
  assign wptr_o     = ptr_q;
  assign state_o    = st_q;
  assign wrapped_o  = wrap_q;
  assign trig_idx_o = tidx_q;
  assign rec_len_o  = wrap_q ? (AW+1)'(DEPTH) : {1'b0, ptr_q};

  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st_q == CAP_ARMED && ptr_q == '0 && !wrap_q && tidx_q == '0)); // R10
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_DONE && !arm) |=> (st_q == CAP_DONE && $stable(ptr_q))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_IDLE && !arm) |=> (st_q == CAP_IDLE)); // R8
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !arm) |=> wrap_q); // R4
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/cap_engine.sv
module cap_engine
  import cap_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  input  logic          use_int_clk,
  input  logic [RW-1:0] rate_div,
  input  logic [PW-1:0] post_cnt,
  input  logic          qual_en,
  input  logic [DW-1:0] qual_mask,
  input  logic [DW-1:0] qual_value,
  input  logic          samp_valid,
  output logic          samp_ready,
  input  logic [DW-1:0] samp_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    state,
  output logic          wrapped,
  output logic [AW-1:0] trig_idx,
  output logic [AW:0]   rec_len
);
  logic          open_w;
  logic          pass_w;
  logic          take_w;
  logic          we_w;
  logic [AW-1:0] wptr_w;
  cap_state_e    st_w;
  logic          wrap_w;
  logic [AW-1:0] base_w;
  logic [AW-1:0] raddr_w;
  logic          rv_q;

  cap_rate_gen #(.RW(RW)) u_rate (
    .clk(clk), .rst_n(rst_n), .use_int(use_int_clk),
    .rate_div(rate_div), .open_o(open_w)
  );

  cap_qual #(.DW(DW)) u_qual (
    .data(samp_data), .mask(qual_mask), .value(qual_value),
    .enable(qual_en), .pass_o(pass_w)
  );

  assign samp_ready = open_w;
  assign take_w     = samp_valid && open_w;

  cap_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .take(take_w), .pass(pass_w),
    .trig(trig), .post_cnt(post_cnt), .we_o(we_w), .wptr_o(wptr_w),
    .state_o(st_w), .wrapped_o(wrap_w), .trig_idx_o(trig_idx),
    .rec_len_o(rec_len)
  );

  assign base_w  = wrap_w ? wptr_w : '0;
  assign raddr_w = base_w + rd_idx;

  cap_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(we_w), .waddr(wptr_w), .wdata(samp_data),
    .re(rd_en), .raddr(raddr_w), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rd_en && (st_w == CAP_DONE);
  end

  assign rd_valid = rv_q;
  assign state    = st_w;
  assign wrapped  = wrap_w;

  AST_TAKE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    we_w |-> (samp_valid && samp_ready)); // R2
  AST_QUAL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_en && ((samp_data & qual_mask) != (qual_value & qual_mask))) |-> !we_w); // R5
  AST_NO_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == CAP_IDLE || st_w == CAP_DONE) |-> !we_w); // R7
  AST_READ_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> ($past(st_w) == CAP_DONE)); // R9
endmodule

// File: tb/cap_engine_tb.sv
module cap_engine_tb;
  localparam int DW = 8, AW = 4, PW = 8, RW = 8;

  logic clk = 0, rst_n = 0;
  logic arm = 0, trig = 0, use_int_clk = 0, qual_en = 0;
  logic [RW-1:0] rate_div = '0;
  logic [PW-1:0] post_cnt = '0;
  logic [DW-1:0] qual_mask = '0, qual_value = '0, samp_data = '0;
  logic samp_valid = 0, rd_en = 0;
  logic [AW-1:0] rd_idx = '0;
  logic samp_ready, rd_valid, wrapped;
  logic [DW-1:0] rd_data;
  logic [1:0] state;
  logic [AW-1:0] trig_idx;
  logic [AW:0] rec_len;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cap_engine #(.DW(DW), .AW(AW), .PW(PW), .RW(RW)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic push(input logic [DW-1:0] d, input logic t);
    @(negedge clk);
    samp_valid = 1; samp_data = d; trig = t;
    while (!samp_ready) @(negedge clk);
    @(negedge clk);
    samp_valid = 0; trig = 0;
  endtask

  task automatic rd(input int idx, input int exp, input string tag);
    @(negedge clk); rd_en = 1; rd_idx = AW'(idx);
    @(negedge clk); rd_en = 0;
    chk({tag, " rd_valid"}, rd_valid, 1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 wrapped", wrapped, 0);
    chk("R1 trig_idx", trig_idx, 0);
    chk("R1 rec_len", rec_len, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R2 ext ready", samp_ready, 1);
  endtask

  task automatic t_idle_trig();
    push(8'h33, 1);
    chk("R8 idle trig state", state, 0);
    chk("R8 idle rec_len", rec_len, 0);
  endtask

  task automatic t_short();
    post_cnt = 2;
    do_arm();
    chk("R10 armed", state, 1);
    @(negedge clk); rd_en = 1; rd_idx = 0;
    @(negedge clk); rd_en = 0;
    chk("R9 no read in armed", rd_valid, 0);
    push(10, 0); push(11, 0); push(12, 1);
    chk("R6 post state", state, 2);
    chk("R6 trig_idx", trig_idx, 2);
    push(13, 0);
    chk("R7 still post", state, 2);
    push(14, 0);
    chk("R7 done", state, 3);
    chk("R4 no wrap", wrapped, 0);
    chk("R4 rec_len", rec_len, 5);
    for (int j = 0; j < 5; j++) rd(j, 10 + j, "R3 short");
    push(99, 1);
    chk("R8 done trig state", state, 3);
    chk("R8 done rec_len", rec_len, 5);
    rd(0, 10, "R8 record kept");
  endtask

  task automatic t_wrap();
    post_cnt = 3;
    do_arm();
    chk("R10 wrapped cleared", wrapped, 0);
    chk("R10 trig_idx cleared", trig_idx, 0);
    chk("R10 rec_len cleared", rec_len, 0);
    for (int k = 0; k < 20; k++) push(DW'(100 + k), 0);
    chk("R4 wrapped", wrapped, 1);
    chk("R4 rec_len full", rec_len, 16);
    chk("R3 armed after wrap", state, 1);
    push(200, 1);
    chk("R6 trig_idx wrap", trig_idx, 4);
    push(201, 0); push(202, 0); push(203, 0);
    chk("R7 done wrap", state, 3);
    for (int j = 0; j < 16; j++)
      rd(j, (j < 12) ? 108 + j : 200 + (j - 12), "R9 wrap");
  endtask

  task automatic t_post_zero();
    post_cnt = 0;
    do_arm();
    push(1, 0); push(2, 0); push(3, 1);
    chk("R6 post0 done", state, 3);
    chk("R6 post0 trig_idx", trig_idx, 2);
    rd(2, 3, "R9 post0");
  endtask

  task automatic t_qual();
    post_cnt = 1; qual_en = 1; qual_mask = 8'hF0; qual_value = 8'hA0;
    do_arm();
    push(8'hA1, 0);
    push(8'h51, 1);
    chk("R5 skipped trig", state, 1);
    chk("R5 skipped len", rec_len, 1);
    push(8'hA2, 0);
    push(8'hB3, 0);
    push(8'hA4, 1);
    chk("R5 trig state", state, 2);
    chk("R5 trig_idx", trig_idx, 2);
    push(8'hC0, 0);
    chk("R5 skip post", state, 2);
    push(8'hA5, 0);
    chk("R5 done", state, 3);
    chk("R5 rec_len", rec_len, 4);
    rd(0, 8'hA1, "R5"); rd(1, 8'hA2, "R5");
    rd(2, 8'hA4, "R5"); rd(3, 8'hA5, "R5");
    qual_en = 0;
  endtask

  task automatic t_rate();
    int hi;
    int gap;
    int last;
    rate_div = 3; use_int_clk = 1;
    hi = 0; gap = 0; last = -1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (samp_ready) begin
        if (last >= 0 && c - last != 4) gap++;
        last = c; hi++;
      end
    end
    chk("R2 int ready count", hi, 4);
    chk("R2 int ready spacing", gap, 0);
    post_cnt = 1;
    do_arm();
    push(7, 1); push(8, 0);
    chk("R2 int done", state, 3);
    rd(0, 7, "R2 int"); rd(1, 8, "R2 int");
    use_int_clk = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_trig();
    t_short();
    t_wrap();
    t_post_zero();
    t_qual();
    t_rate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule